// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Arithmetic Modes

The block multiplies two 32-bit operands and adds the product to, or subtracts it from, one of four 48-bit accumulators. A command can ask for 16-bit halves instead of full words, can scale the product, and can also fold the same product into a second accumulator in the same operation. A mode register picks one of three arithmetic kinds: unsigned integer, signed integer or fractional. It also decides whether results that leave the accumulator range are clamped or left to wrap.

Each accumulator has a sticky overflow bit. The unit drives N, Z and V condition flags. A host port reads and writes the accumulators, the mode register, the sticky bits and an address mask register, and it can copy one accumulator into another. Commands use a valid/ready handshake and finish with a one-cycle done pulse.

Top module: `mac_unit`

## Requirements
- R1: Word operands (cmd_long=0) take a 16-bit half chosen by cmd_x_hi / cmd_y_hi. Fractional mode: the upper half stays in bits 31:16 with bits 15:0 cleared, and the lower half moves up into bits 31:16. Signed mode: the half is sign-extended. Unsigned mode: the half is zero-extended. Long operands (cmd_long=1) are used whole.
- R2: Mode register bits are bit0 saturate enable, bit1 signed and bit2 fractional. Fractional overrides signed. In fractional mode the product is the signed 64-bit product doubled and then arithmetically shifted right by 16. Signed mode multiplies as two's complement and unsigned mode multiplies as unsigned.
- R3: In the integer modes, scale code 1 shifts the product left one bit and code 3 shifts it right one bit (arithmetic). Codes 0 and 2, and every code in fractional mode, leave the product unchanged.
- R4: cmd_sub=1 subtracts the product and cmd_sub=0 adds it. The accumulator range is [-2^47, 2^47-1] in the signed and fractional modes and [0, 2^48-1] in unsigned mode. A result outside that range sets the accumulator's sticky bit. With saturation on, the result is clamped to the bound it crossed. With saturation off, it keeps its low 48 bits.
- R5: With saturation on, an accumulate whose target already has its sticky bit set is skipped, and that accumulator keeps its value. With saturation off, there is no skip.
- R6: With cmd_dual=1, the same product is also accumulated into cmd_acc2 using cmd_sub2, and that second accumulate obeys the same skip rule. If cmd_acc2 equals cmd_acc, the second accumulate does not happen.
- R7: After an operation, flag_n is bit 47 and flag_z shows a zero value, both taken from the final target: cmd_acc2 in effective dual operations, cmd_acc otherwise. flag_v shows an overflow of that accumulate in this operation, and is 0 if the accumulate was skipped. A copy sets N and Z from the copied value and clears V.
- R8: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready is low for the next cycle. After the second clock edge following acceptance, done is high for exactly one cycle, and the accumulators, sticky bits and flags already hold the results.
- R9: A host write to the mask register (address 5) stores the value ORed with 0xFFFF0000, so bits 31:16 always read as ones. The mask resets to 0xFFFFFFFF.
- R10: host_raddr 0 to 3 reads the accumulators, 4 reads the mode, 5 reads the mask, 6 reads the sticky bits (bit i belongs to accumulator i), and 7 reads zero. host_wr writes the same map. Host writes and copies that arrive while a command is in flight (cmd_ready low) are ignored. A copy in the same cycle as a host write is ignored.
- R11: After reset, every accumulator, sticky bit, flag, the mode and done are zero, cmd_ready is high and the mask is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_x | input | 32 | First operand |
| cmd_y | input | 32 | Second operand |
| cmd_long | input | 1 | 1: full 32-bit operands, 0: 16-bit halves |
| cmd_x_hi | input | 1 | Take the upper half of cmd_x |
| cmd_y_hi | input | 1 | Take the upper half of cmd_y |
| cmd_scale | input | 2 | Product scale code |
| cmd_sub | input | 1 | Subtract from the primary accumulator |
| cmd_acc | input | 2 | Primary accumulator index |
| cmd_dual | input | 1 | Also accumulate into cmd_acc2 |
| cmd_acc2 | input | 2 | Second accumulator index |
| cmd_sub2 | input | 1 | Subtract from the second accumulator |
| done | output | 1 | Operation complete pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| host_wr | input | 1 | Host register write |
| host_waddr | input | 3 | Host write address |
| host_wdata | input | 48 | Host write data |
| host_raddr | input | 3 | Host read address |
| host_rdata | output | 48 | Host read data |
| copy_req | input | 1 | Copy one accumulator into another |
| copy_src | input | 2 | Copy source index |
| copy_dst | input | 2 | Copy destination index |

## Verification
The hardest case to reach is an accumulate that gets skipped because the target was already overflowed. The accumulator must first be pushed close to a range bound, which the bench does by loading it through the host port. A large product then crosses the bound with saturation on, and only after that can a later command show the skip. The bench runs this in dual form as well, with the sticky bit preset on the second target only, so that one lane writes while the other holds and the flags follow the held lane. Host writes during the busy cycle are stimulated on purpose and then read back to show that nothing changed.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate unit.
// Assumes: mode register layout bit0 saturate, bit1 signed, bit2 fractional.
package mac_pkg;

    typedef enum logic [1:0] {
        K_UNS  = 2'd0,
        K_SGN  = 2'd1,
        K_FRAC = 2'd2
    } arith_e;

    typedef struct packed {
        logic frac;
        logic sgn;
        logic sat;
    } mode_t;

    // Fractional overrides signed, signed overrides unsigned.
    function automatic arith_e kind_of(input mode_t m);
        if (m.frac)
            return K_FRAC;
        else if (m.sgn)
            return K_SGN;
        return K_UNS;
    endfunction

endpackage

// File: rtl/mac_operand.sv
// Operand conditioner: picks a full word or a 16-bit half and places it
// according to the arithmetic kind.
// Assumes: DW is even; the result is read as signed in K_SGN/K_FRAC.
module mac_operand
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src,
    input  logic          sel_hi,
    input  logic          is_long,
    input  arith_e        kind,
    output logic [DW-1:0] half
);
    localparam int HW = DW / 2;

    // Half selection and placement per arithmetic kind.
    always_comb begin
        if (is_long) begin
            half = src;
        end else begin
            unique case (kind)
                K_FRAC:  half = sel_hi ? {src[DW-1:HW], {HW{1'b0}}}
                                       : {src[HW-1:0],  {HW{1'b0}}};
                K_SGN:   half = sel_hi ? {{HW{src[DW-1]}}, src[DW-1:HW]}
                                       : {{HW{src[HW-1]}}, src[HW-1:0]};
                default: half = sel_hi ? {{HW{1'b0}}, src[DW-1:HW]}
                                       : {{HW{1'b0}}, src[HW-1:0]};
            endcase
        end
    end
endmodule

// File: rtl/mac_product.sv
// Multiplier with integer scaling and fractional alignment.
// Assumes: PW is wide enough for the unsigned product shifted left one bit.
module mac_product
    import mac_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 2 * DW + 4
) (
    input  logic [DW-1:0]        x,
    input  logic [DW-1:0]        y,
    input  arith_e               kind,
    input  logic [1:0]           scale,
    output logic signed [PW-1:0] prod
);
    localparam int FSH = DW / 2 - 1;

    logic signed [PW-1:0] xe, ye, raw;

    // Extend operands by arithmetic kind.
    always_comb begin
        if (kind == K_UNS) begin
            xe = {{(PW-DW){1'b0}}, x};
            ye = {{(PW-DW){1'b0}}, y};
        end else begin
            xe = {{(PW-DW){x[DW-1]}}, x};
            ye = {{(PW-DW){y[DW-1]}}, y};
        end
    end

    assign raw = xe * ye;

    // Fractional alignment or integer scaling.
    always_comb begin
        if (kind == K_FRAC) begin
            prod = raw >>> FSH;
        end else begin
            unique case (scale)
                2'd1:    prod = raw <<< 1;
                2'd3:    prod = raw >>> 1;
                default: prod = raw;
            endcase
        end
    end
endmodule

// File: rtl/mac_accum.sv
// One accumulate lane: adds or subtracts a product, detects range exit,
// and clamps or wraps.
// Assumes: SW exceeds both AW and PW so the sum never loses bits.
module mac_accum
    import mac_pkg::*;
#(
    parameter int AW = 48,
    parameter int PW = 68,
    parameter int SW = 70
) (
    input  logic [AW-1:0]        acc_in,
    input  logic signed [PW-1:0] prod,
    input  logic                 sub,
    input  arith_e               kind,
    input  logic                 sat_en,
    output logic [AW-1:0]        acc_out,
    output logic                 ovf
);
    logic signed [SW-1:0] a_ext, p_ext, sum, lo, hi;
    logic below, above;

    // Extend the operands and form the sum together with the range bounds.
    always_comb begin
        if (kind == K_UNS) begin
            a_ext = {{(SW-AW){1'b0}}, acc_in};
            hi    = {{(SW-AW){1'b0}}, {AW{1'b1}}};
            lo    = '0;
        end else begin
            a_ext = {{(SW-AW){acc_in[AW-1]}}, acc_in};
            hi    = {{(SW-AW+1){1'b0}}, {(AW-1){1'b1}}};
            lo    = {{(SW-AW+1){1'b1}}, {(AW-1){1'b0}}};
        end
        p_ext = {{(SW-PW){prod[PW-1]}}, prod};
        sum   = sub ? (a_ext - p_ext) : (a_ext + p_ext);
    end

    assign below = (sum < lo);
    assign above = (sum > hi);
    assign ovf   = below | above;

    // Clamp with saturation on, otherwise keep the low bits.
    always_comb begin
        if (ovf && sat_en)
            acc_out = below ? lo[AW-1:0] : hi[AW-1:0];
        else
            acc_out = sum[AW-1:0];
    end
endmodule

// File: rtl/mac_unit.sv
// Multiply-accumulate unit with four accumulators. Stage 1 registers the
// product and stage 2 accumulates into one or two accumulators.
// Assumes: N_ACC >= 3 so the three control registers fit after the
// accumulators in the host map; ACC_W >= DATA_W.
module mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48,
    parameter int N_ACC  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [DATA_W-1:0]          cmd_x,
    input  logic [DATA_W-1:0]          cmd_y,
    input  logic                       cmd_long,
    input  logic                       cmd_x_hi,
    input  logic                       cmd_y_hi,
    input  logic [1:0]                 cmd_scale,
    input  logic                       cmd_sub,
    input  logic [$clog2(N_ACC)-1:0]   cmd_acc,
    input  logic                       cmd_dual,
    input  logic [$clog2(N_ACC)-1:0]   cmd_acc2,
    input  logic                       cmd_sub2,
    output logic                       done,
    output logic                       flag_n,
    output logic                       flag_z,
    output logic                       flag_v,
    input  logic                       host_wr,
    input  logic [$clog2(N_ACC+3)-1:0] host_waddr,
    input  logic [ACC_W-1:0]           host_wdata,
    input  logic [$clog2(N_ACC+3)-1:0] host_raddr,
    output logic [ACC_W-1:0]           host_rdata,
    input  logic                       copy_req,
    input  logic [$clog2(N_ACC)-1:0]   copy_src,
    input  logic [$clog2(N_ACC)-1:0]   copy_dst
);
    localparam int IW  = $clog2(N_ACC);
    localparam int HAW = $clog2(N_ACC + 3);
    localparam int PW  = 2 * DATA_W + 4;
    localparam int SW  = ((PW > ACC_W) ? PW : ACC_W) + 2;
    localparam logic [HAW-1:0] A_MODE   = HAW'(N_ACC);
    localparam logic [HAW-1:0] A_MASK   = HAW'(N_ACC + 1);
    localparam logic [HAW-1:0] A_STICKY = HAW'(N_ACC + 2);
    localparam logic [DATA_W-1:0] MASK_HI = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};

    logic [ACC_W-1:0]  acc_q [N_ACC];
    logic [N_ACC-1:0]  sticky_q;
    mode_t             mode_q;
    logic [DATA_W-1:0] mask_q;

    arith_e            cur_kind;
    logic [DATA_W-1:0] opx, opy;
    logic signed [PW-1:0] prod_c;

    logic                 s1_vld;
    logic signed [PW-1:0] s1_prod;
    arith_e               s1_kind;
    logic                 s1_sat, s1_sub, s1_dual, s1_sub2;
    logic [IW-1:0]        s1_idx, s1_idx2;

    logic accept, host_go, copy_go, host_acc_wr;

    assign cur_kind  = kind_of(mode_q);
    assign cmd_ready = !s1_vld;
    assign accept    = cmd_valid && cmd_ready;
    assign host_go   = host_wr && !s1_vld;
    assign copy_go   = copy_req && !host_wr && !s1_vld;
    assign host_acc_wr = host_go && (host_waddr < HAW'(N_ACC));

    mac_operand #(.DW(DATA_W)) u_opx (
        .src(cmd_x), .sel_hi(cmd_x_hi), .is_long(cmd_long), .kind(cur_kind), .half(opx)
    );
    mac_operand #(.DW(DATA_W)) u_opy (
        .src(cmd_y), .sel_hi(cmd_y_hi), .is_long(cmd_long), .kind(cur_kind), .half(opy)
    );
    mac_product #(.DW(DATA_W), .PW(PW)) u_mul (
        .x(opx), .y(opy), .kind(cur_kind), .scale(cmd_scale), .prod(prod_c)
    );

    // Stage 1: capture the product and the command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_prod <= '0;
            s1_kind <= K_UNS;
            s1_sat  <= 1'b0;
            s1_sub  <= 1'b0;
            s1_dual <= 1'b0;
            s1_sub2 <= 1'b0;
            s1_idx  <= '0;
            s1_idx2 <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) begin
                s1_prod <= prod_c;
                s1_kind <= cur_kind;
                s1_sat  <= mode_q.sat;
                s1_sub  <= cmd_sub;
                s1_dual <= cmd_dual;
                s1_sub2 <= cmd_sub2;
                s1_idx  <= cmd_acc;
                s1_idx2 <= cmd_acc2;
            end
        end
    end

    // Stage 2 lanes: lane 0 is the primary target, lane 1 the dual target.
    logic [IW-1:0]    lane_idx  [2];
    logic             lane_sub  [2];
    logic [ACC_W-1:0] lane_in   [2];
    logic [ACC_W-1:0] lane_out  [2];
    logic             lane_ovf  [2];
    logic             lane_en   [2];
    logic             lane_skip [2];
    logic             lane_wr   [2];

    // Lane selection, enable and sticky-skip decision.
    always_comb begin
        lane_idx[0] = s1_idx;
        lane_idx[1] = s1_idx2;
        lane_sub[0] = s1_sub;
        lane_sub[1] = s1_sub2;
        lane_en[0]  = 1'b1;
        lane_en[1]  = s1_dual && (s1_idx2 != s1_idx);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_in[g]   = acc_q[lane_idx[g]];
        assign lane_skip[g] = s1_sat && sticky_q[lane_idx[g]];
        assign lane_wr[g]   = lane_en[g] && !lane_skip[g];
        mac_accum #(.AW(ACC_W), .PW(PW), .SW(SW)) u_acc (
            .acc_in(lane_in[g]), .prod(s1_prod), .sub(lane_sub[g]),
            .kind(s1_kind), .sat_en(s1_sat),
            .acc_out(lane_out[g]), .ovf(lane_ovf[g])
        );
    end

    logic             fl_sel;
    logic [ACC_W-1:0] fl_val;
    logic             fl_ovf;

    // Select the lane that feeds the condition flags.
    always_comb begin
        fl_sel = lane_en[1];
        fl_val = lane_skip[fl_sel] ? lane_in[fl_sel] : lane_out[fl_sel];
        fl_ovf = lane_ovf[fl_sel] && !lane_skip[fl_sel];
    end

    // Accumulator storage: lane writes, host writes, copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
        end else if (s1_vld) begin
            for (int g = 0; g < 2; g++)
                if (lane_wr[g]) acc_q[lane_idx[g]] <= lane_out[g];
        end else if (host_acc_wr) begin
            acc_q[host_waddr[IW-1:0]] <= host_wdata;
        end else if (copy_go) begin
            acc_q[copy_dst] <= acc_q[copy_src];
        end
    end

    // Sticky overflow bits: set by lanes, replaced by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else if (s1_vld) begin
            for (int g = 0; g < 2; g++)
                if (lane_wr[g] && lane_ovf[g]) sticky_q[lane_idx[g]] <= 1'b1;
        end else if (host_go && host_waddr == A_STICKY) begin
            sticky_q <= host_wdata[N_ACC-1:0];
        end
    end

    // Mode and address mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '1;
        end else if (host_go) begin
            if (host_waddr == A_MODE) mode_q <= mode_t'(host_wdata[2:0]);
            if (host_waddr == A_MASK) mask_q <= host_wdata[DATA_W-1:0] | MASK_HI;
        end
    end

    // Condition flags and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= s1_vld;
            if (s1_vld) begin
                flag_n <= fl_val[ACC_W-1];
                flag_z <= (fl_val == '0);
                flag_v <= fl_ovf;
            end else if (copy_go) begin
                flag_n <= acc_q[copy_src][ACC_W-1];
                flag_z <= (acc_q[copy_src] == '0);
                flag_v <= 1'b0;
            end
        end
    end

    // Host read multiplexer.
    always_comb begin
        if (host_raddr < HAW'(N_ACC))
            host_rdata = acc_q[host_raddr[IW-1:0]];
        else if (host_raddr == A_MODE)
            host_rdata = {{(ACC_W-3){1'b0}}, mode_q};
        else if (host_raddr == A_MASK)
            host_rdata = {{(ACC_W-DATA_W){1'b0}}, mask_q};
        else if (host_raddr == A_STICKY)
            host_rdata = {{(ACC_W-N_ACC){1'b0}}, sticky_q};
        else
            host_rdata = '0;
    end

    // R8: the unit is busy for the cycle after acceptance.
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!cmd_ready && !done));
    // R8: done follows two edges after acceptance.
    a_r8_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done);
    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: upper mask half is always ones.
    a_r9_mask_upper: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[DATA_W-1:DATA_W/2] == {(DATA_W/2){1'b1}});
    // R5: a skipped primary lane leaves its accumulator unchanged.
    a_r5_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && lane_skip[0]) |=> (acc_q[$past(s1_idx)] == $past(lane_in[0])));
    // R4: an operation never clears a sticky bit.
    a_r4_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cmd_valid = 0, cmd_ready;
    logic [31:0] cmd_x = 0, cmd_y = 0;
    logic        cmd_long = 0, cmd_x_hi = 0, cmd_y_hi = 0;
    logic [1:0]  cmd_scale = 0;
    logic        cmd_sub = 0, cmd_dual = 0, cmd_sub2 = 0;
    logic [1:0]  cmd_acc = 0, cmd_acc2 = 0;
    logic        done, flag_n, flag_z, flag_v;
    logic        host_wr = 0;
    logic [2:0]  host_waddr = 0, host_raddr = 0;
    logic [47:0] host_wdata = 0, host_rdata;
    logic        copy_req = 0;
    logic [1:0]  copy_src = 0, copy_dst = 0;

    mac_unit u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model state.
    logic [47:0] m_acc [4];
    logic [3:0]  m_sticky;
    logic [2:0]  m_mode;
    logic [31:0] m_mask;
    logic        m_n, m_z, m_v;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic signed [127:0] m_half(input logic [31:0] v, input bit hi,
                                                   input bit lng, input int kind);
        logic [31:0] t;
        if (lng) return (kind == 0) ? {96'b0, v} : {{96{v[31]}}, v};
        if (kind == 2) begin
            t = hi ? (v & 32'hFFFF0000) : (v << 16);
            return {{96{t[31]}}, t};
        end
        t = hi ? (v >> 16) : (v & 32'h0000FFFF);
        if (kind == 1) return {{112{t[15]}}, t[15:0]};
        return {96'b0, t};
    endfunction

    task automatic m_lane(input int i, input bit sub, input logic signed [127:0] p,
                          input int kind, input bit sat);
        logic signed [127:0] a, s, lo, hi;
        bit ovf;
        if (sat && m_sticky[i]) begin
            m_v = 0;
        end else begin
            a  = (kind == 0) ? {80'b0, m_acc[i]} : {{80{m_acc[i][47]}}, m_acc[i]};
            s  = sub ? a - p : a + p;
            hi = (kind == 0) ? 128'sh0000_FFFF_FFFF_FFFF : 128'sh0000_7FFF_FFFF_FFFF;
            lo = (kind == 0) ? 128'sh0 : -128'sh0000_8000_0000_0000;
            ovf = (s < lo) || (s > hi);
            if (ovf) m_sticky[i] = 1'b1;
            if (ovf && sat) s = (s < lo) ? lo : hi;
            m_acc[i] = s[47:0];
            m_v = ovf;
        end
        m_n = m_acc[i][47];
        m_z = (m_acc[i] == 48'h0);
    endtask

    task automatic m_apply(input logic [31:0] x, y, input bit lng, xh, yh,
                           input int sc, input bit sub, input int idx,
                           input bit dual, input int idx2, input bit sub2);
        int kind;
        logic signed [127:0] p;
        kind = m_mode[2] ? 2 : (m_mode[1] ? 1 : 0);
        p = m_half(x, xh, lng, kind) * m_half(y, yh, lng, kind);
        if (kind == 2) p = (p * 2) >>> 16;
        else if (sc == 1) p = p * 2;
        else if (sc == 3) p = p >>> 1;
        m_lane(idx, sub, p, kind, m_mode[0]);
        if (dual && idx2 != idx) m_lane(idx2, sub2, p, kind, m_mode[0]);
    endtask

    task automatic cmp_all(input string req);
        for (int i = 0; i < 4; i++) begin
            host_raddr = 3'(i); #1;
            chk(req, {16'b0, host_rdata}, {16'b0, m_acc[i]});
        end
        host_raddr = 3'd6; #1;
        chk(req, {16'b0, host_rdata}, {60'b0, m_sticky});
        chk(req, {61'b0, flag_n, flag_z, flag_v}, {61'b0, m_n, m_z, m_v});
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [47:0] d);
        @(negedge clk);
        host_wr = 1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
        if (a < 4) m_acc[a] = d;
        else if (a == 4) m_mode = d[2:0];
        else if (a == 5) m_mask = d[31:0] | 32'hFFFF0000;
        else if (a == 6) m_sticky = d[3:0];
    endtask

    task automatic op(input string req, input logic [31:0] x, y, input bit lng, xh, yh,
                      input int sc, input bit sub, input int idx,
                      input bit dual = 0, input int idx2 = 0, input bit sub2 = 0,
                      input bit poke = 0);
        @(negedge clk);
        cmd_valid = 1; cmd_x = x; cmd_y = y; cmd_long = lng; cmd_x_hi = xh; cmd_y_hi = yh;
        cmd_scale = 2'(sc); cmd_sub = sub; cmd_acc = 2'(idx);
        cmd_dual = dual; cmd_acc2 = 2'(idx2); cmd_sub2 = sub2;
        @(negedge clk);
        cmd_valid = 0;
        chk("R8 ready low while busy", {63'b0, cmd_ready}, 64'd0);
        chk("R8 done not yet", {63'b0, done}, 64'd0);
        if (poke) begin
            host_wr = 1; host_waddr = 3'(idx); host_wdata = 48'h1234_5678_9ABC;
            copy_req = 1; copy_src = 2'(idx); copy_dst = 2'(idx2);
        end
        m_apply(x, y, lng, xh, yh, sc, sub, idx, dual, idx2, sub2);
        @(negedge clk);
        host_wr = 0; copy_req = 0;
        chk("R8 done pulse", {63'b0, done}, 64'd1);
        cmp_all(req);
    endtask

    task automatic do_copy(input int s, input int d, input bit with_wr);
        @(negedge clk);
        copy_req = 1; copy_src = 2'(s); copy_dst = 2'(d);
        if (with_wr) begin host_wr = 1; host_waddr = 3'd3; host_wdata = 48'h0000_0000_0042; end
        @(negedge clk);
        copy_req = 0; host_wr = 0;
        if (with_wr) m_acc[3] = 48'h42;
        else begin
            m_acc[d] = m_acc[s];
            m_n = m_acc[d][47]; m_z = (m_acc[d] == 0); m_v = 0;
        end
        cmp_all(with_wr ? "R10 copy ignored with host write" : "R7 copy flags");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_sticky = 0; m_mode = 0; m_mask = 32'hFFFFFFFF; m_n = 0; m_z = 0; m_v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", {63'b0, cmd_ready}, 64'd1);
        chk("R11 done", {63'b0, done}, 64'd0);
        cmp_all("R11 reset contents");
        host_raddr = 3'd5; #1; chk("R11 mask", {16'b0, host_rdata}, 64'hFFFF_FFFF);
        host_raddr = 3'd4; #1; chk("R11 mode", {16'b0, host_rdata}, 64'd0);
        // R9 mask write
        hwrite(3'd5, 48'h0000_0000_1234);
        host_raddr = 3'd5; #1; chk("R9 mask OR", {16'b0, host_rdata}, {32'b0, m_mask});
        host_raddr = 3'd7; #1; chk("R10 unused address", {16'b0, host_rdata}, 64'd0);
        // R2 unsigned, long and word (R1)
        op("R2 unsigned long", 32'd3, 32'd5, 1, 0, 0, 0, 0, 0);
        op("R1 unsigned halves", 32'hABCD_0002, 32'h0003_FFFF, 0, 1, 0, 0, 0, 0);
        op("R4 unsigned wrap", 32'h0000_0002, 32'h0003_0000, 0, 0, 1, 0, 1, 1);
        // R1/R3 signed mode
        hwrite(3'd4, 48'd2);
        host_raddr = 3'd4; #1; chk("R10 mode read", {16'b0, host_rdata}, 64'd2);
        op("R1 signed halves", 32'h8000_7FFF, 32'h1234_FFFE, 0, 1, 0, 0, 1, 2);
        op("R3 scale 0", 32'hFFFF_FFF9, 32'd3, 1, 0, 0, 0, 0, 3);
        op("R3 scale 1", 32'hFFFF_FFF9, 32'd3, 1, 0, 0, 1, 0, 3);
        op("R3 scale 2", 32'hFFFF_FFF9, 32'd3, 1, 0, 0, 2, 0, 3);
        op("R3 scale 3", 32'hFFFF_FFF9, 32'd3, 1, 0, 0, 3, 1, 3);
        // R2 fractional, with and without signed bit
        hwrite(3'd4, 48'd4);
        op("R2 fractional long", 32'h4000_0000, 32'hC000_0000, 1, 0, 0, 1, 0, 0);
        op("R1 fractional halves", 32'h4000_1234, 32'h7FFF_C000, 0, 1, 0, 3, 0, 1);
        hwrite(3'd4, 48'd6);
        op("R2 fractional over signed", 32'h0000_6000, 32'h2000_0000, 0, 0, 1, 1, 1, 2);
        // R4/R5 signed saturation
        hwrite(3'd4, 48'd3);
        hwrite(3'd6, 48'd0);
        hwrite(3'd0, 48'h7FFF_FFFF_FF00);
        op("R4 signed clamp high", 32'h0001_0000, 32'h0001_0000, 1, 0, 0, 0, 0, 0);
        op("R5 skip on sticky", 32'd7, 32'd9, 1, 0, 0, 0, 1, 0);
        hwrite(3'd1, 48'h8000_0000_0010);
        op("R4 signed clamp low", 32'h0001_0000, 32'h0001_0000, 1, 0, 0, 0, 1, 1);
        // R4 unsigned saturation
        hwrite(3'd4, 48'd1);
        hwrite(3'd6, 48'd0);
        hwrite(3'd2, 48'd5);
        op("R4 unsigned clamp zero", 32'd10, 32'd1, 1, 0, 0, 0, 1, 2);
        hwrite(3'd3, 48'hFFFF_FFFF_FFF0);
        op("R4 unsigned clamp ones", 32'h100, 32'd1, 1, 0, 0, 0, 0, 3);
        // R4/R5 wrap with saturation off, no skip
        hwrite(3'd4, 48'd2);
        hwrite(3'd0, 48'h7FFF_FFFF_FFFF);
        op("R4 signed wrap", 32'd1, 32'd1, 1, 0, 0, 0, 0, 0);
        op("R5 no skip when saturation off", 32'd2, 32'd3, 1, 0, 0, 0, 0, 0);
        // R6 dual
        hwrite(3'd6, 48'd0);
        op("R6 dual accumulate", 32'd11, 32'hFFFF_FFFD, 1, 0, 0, 0, 0, 1, 1, 2, 1);
        op("R6 dual same index", 32'd4, 32'd5, 1, 0, 0, 0, 0, 3, 1, 3, 1);
        hwrite(3'd4, 48'd3);
        hwrite(3'd6, 48'h4);
        op("R6 dual second lane skipped", 32'd6, 32'd6, 1, 0, 0, 0, 0, 0, 1, 2, 0);
        // R7 copy
        do_copy(1, 0, 0);
        do_copy(2, 1, 1);
        // R10 host writes during busy cycle ignored
        op("R10 busy host write ignored", 32'd2, 32'd2, 1, 0, 0, 0, 0, 1, 0, 3, 0, 1);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule